// File: doc/BRIEF.md
# Page-relative branch and condition unit

This unit forms the next program address for the short branches of a 4-bit processor whose 12-bit program space is cut into 256-word pages. It decides whether a conditional jump is taken from a 4-bit condition code. It also handles the increment-and-skip loop branch, an indirect jump through an 8-bit register pair, and the address of an indirect data fetch that uses register pair 0.

Each request is presented for one cycle with `valid_i`. The inputs are the address of the instruction's first word, the two instruction nibbles, the second instruction word, the status inputs and the register contents. One cycle later the unit returns registered results: the taken flag, a fetch flag, the 12-bit address and the incremented loop register.

Every short target keeps the page number and replaces only the low 8 bits. The page comes from the address that follows the instruction. A branch at the end of a page therefore lands in the next page.

Top module: `branch_unit`

## Requirements
- R1: Outputs are registered. A request sampled with `valid_i` high appears on the outputs at the next rising clock edge with `valid_o` high. A cycle without `valid_i` gives `valid_o` low. Reset clears every output to 0.
- R2: Decoding uses the upper nibble `opr_i`. Value 4'b0001 is a conditional jump and 4'b0111 is the loop branch. Value 4'b0011 is an indirect jump when `opa_i[0]` is 1 and an indirect fetch when `opa_i[0]` is 0. Any other value gives `taken_o`=0, `fetch_o`=0 and `addr_o`=pc+1.
- R3: For a conditional jump, `opa_i[3]` is the invert bit. `opa_i[2]` enables the accumulator-zero test, `opa_i[1]` enables the carry-set test, and `opa_i[0]` enables the test-pin-low test (`test_n_i`=0). The jump is taken when the OR of the enabled tests, XOR the invert bit, is 1. Code 4'b0000 never jumps and 4'b1000 always jumps.
- R4: A taken conditional jump gives `addr_o` = {upper 4 bits of pc+2, `word2_i`}. A jump that is not taken gives pc+2.
- R5: For the loop branch, `reg_inc_o` = (`reg_i`+1) mod 16. The branch is taken exactly when that value is nonzero. The target is formed as in R4, and the fall-through address is pc+2.
- R6: An indirect jump is always taken, with `addr_o` = {upper 4 bits of pc+1, `pair_i`}.
- R7: An indirect fetch gives `fetch_o`=1, `taken_o`=0 and `addr_o` = {upper 4 bits of pc+1, `pair0_i`}.
- R8: Page boundaries are crossed through the incremented address. Two-word branches at word 254 or 255, and one-word indirect operations at word 255, take their page from the next page. Page 15 wraps to page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| pc_i | input | 12 | Address of the instruction's first word |
| opr_i | input | 4 | Upper instruction nibble (operation) |
| opa_i | input | 4 | Lower instruction nibble (modifier or condition) |
| word2_i | input | 8 | Second instruction word (short target) |
| acc_zero_i | input | 1 | Accumulator equals zero |
| carry_i | input | 1 | Carry flag |
| test_n_i | input | 1 | Test pin, active low |
| reg_i | input | 4 | Register addressed by the loop branch |
| pair_i | input | 8 | Register pair addressed by the indirect jump |
| pair0_i | input | 8 | Register pair 0 |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| fetch_o | output | 1 | `addr_o` is an indirect fetch address |
| addr_o | output | 12 | Next program address or fetch address |
| reg_inc_o | output | 4 | Incremented loop register |

## Verification
The hardest case to reach is where condition evaluation meets a page edge. A taken jump or loop branch whose second word sits at word 255, or spills into the next page, must move the page, and so must a wrap from page 15 back to page 0. The stimulus sweeps all 16 condition codes against all eight combinations of accumulator-zero, carry and test pin. It also sweeps all 16 loop-register values. Each sweep is run at instruction addresses 0x0FE, 0x0FF, 0xFFE, 0xFFF and one mid-page address, so every edge case is met under every condition outcome.

// File: rtl/bu_pkg.sv
package bu_pkg;
    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_COND  = 3'd1,
        K_LOOP  = 3'd2,
        K_IJMP  = 3'd3,
        K_FETCH = 3'd4
    } kind_e;
endpackage

// File: rtl/bu_cond.sv
module bu_cond #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] code_i,
    input  logic             acc_zero_i,
    input  logic             carry_i,
    input  logic             test_n_i,
    output logic             hit_o
);
    logic raw;

    always_comb begin
        raw   = (code_i[2] & acc_zero_i) | (code_i[1] & carry_i) | (code_i[0] & ~test_n_i);
        hit_o = raw ^ code_i[3];
    end

    // R3: an all-zero code never fires; invert alone always fires
    always_comb begin
        if (code_i == NIB_W'(0)) a_r3_code_zero: assert (!hit_o);
        if (code_i == NIB_W'(8)) a_r3_code_always: assert (hit_o);
    end
endmodule

// File: rtl/bu_loop.sv
module bu_loop #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] reg_i,
    output logic [NIB_W-1:0] inc_o,
    output logic             nonzero_o
);
    always_comb begin
        inc_o     = reg_i + NIB_W'(1);
        nonzero_o = (reg_i != {NIB_W{1'b1}});
    end

    // R5: the nonzero flag agrees with the wrapped sum
    always_comb a_r5_wrap: assert (nonzero_o == (inc_o != '0));
endmodule

// File: rtl/bu_target.sv
module bu_target #(
    parameter int PC_W  = 12,
    parameter int OFF_W = 8
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic             two_word_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  seq_o,
    output logic [PC_W-1:0]  tgt_o
);
    always_comb begin
        seq_o = pc_i + (two_word_i ? PC_W'(2) : PC_W'(1));
        tgt_o = {seq_o[PC_W-1:OFF_W], off_i};
    end
endmodule

// File: rtl/branch_unit.sv
module branch_unit #(
    parameter int PC_W  = 12,
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [PC_W-1:0]      pc_i,
    input  logic [NIB_W-1:0]     opr_i,
    input  logic [NIB_W-1:0]     opa_i,
    input  logic [2*NIB_W-1:0]   word2_i,
    input  logic                 acc_zero_i,
    input  logic                 carry_i,
    input  logic                 test_n_i,
    input  logic [NIB_W-1:0]     reg_i,
    input  logic [2*NIB_W-1:0]   pair_i,
    input  logic [2*NIB_W-1:0]   pair0_i,
    output logic                 valid_o,
    output logic                 taken_o,
    output logic                 fetch_o,
    output logic [PC_W-1:0]      addr_o,
    output logic [NIB_W-1:0]     reg_inc_o
);
    import bu_pkg::*;

    localparam int OFF_W = 2 * NIB_W;

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic             fetch;
        logic [PC_W-1:0]  addr;
        logic [NIB_W-1:0] reg_inc;
    } res_t;

    res_t             res_d, res_q;
    kind_e            kind;
    logic             cond_hit, loop_nz, two_word;
    logic [NIB_W-1:0] inc_val;
    logic [OFF_W-1:0] off_sel;
    logic [PC_W-1:0]  seq_addr, tgt_addr;

    bu_cond #(.NIB_W(NIB_W)) u_cond (
        .code_i     (opa_i),
        .acc_zero_i (acc_zero_i),
        .carry_i    (carry_i),
        .test_n_i   (test_n_i),
        .hit_o      (cond_hit)
    );

    bu_loop #(.NIB_W(NIB_W)) u_loop (
        .reg_i     (reg_i),
        .inc_o     (inc_val),
        .nonzero_o (loop_nz)
    );

    bu_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc_i       (pc_i),
        .two_word_i (two_word),
        .off_i      (off_sel),
        .seq_o      (seq_addr),
        .tgt_o      (tgt_addr)
    );

    always_comb begin
        if (opr_i == NIB_W'(1))      kind = K_COND;
        else if (opr_i == NIB_W'(7)) kind = K_LOOP;
        else if (opr_i == NIB_W'(3)) kind = opa_i[0] ? K_IJMP : K_FETCH;
        else                         kind = K_NONE;

        two_word = (kind == K_COND) || (kind == K_LOOP);
        case (kind)
            K_IJMP:  off_sel = pair_i;
            K_FETCH: off_sel = pair0_i;
            default: off_sel = word2_i;
        endcase

        res_d         = '0;
        res_d.valid   = valid_i;
        res_d.reg_inc = inc_val;
        res_d.addr    = seq_addr;
        case (kind)
            K_COND: begin
                res_d.taken = cond_hit;
                if (cond_hit) res_d.addr = tgt_addr;
            end
            K_LOOP: begin
                res_d.taken = loop_nz;
                if (loop_nz) res_d.addr = tgt_addr;
            end
            K_IJMP: begin
                res_d.taken = 1'b1;
                res_d.addr  = tgt_addr;
            end
            K_FETCH: begin
                res_d.fetch = 1'b1;
                res_d.addr  = tgt_addr;
            end
            default: ;
        endcase
        if (!valid_i) res_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_o   = res_q.valid;
    assign taken_o   = res_q.taken;
    assign fetch_o   = res_q.fetch;
    assign addr_o    = res_q.addr;
    assign reg_inc_o = res_q.reg_inc;

    // R1: a result follows each request by exactly one edge
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == $past(valid_i));

    // R4: taken short branch keeps the offset from the second word
    a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && taken_o && ($past(opr_i) == NIB_W'(1)))
            |-> (addr_o[OFF_W-1:0] == $past(word2_i)));

    // R4: untaken two-word branch skips both words
    a_r4_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !taken_o && (($past(opr_i) == NIB_W'(1)) || ($past(opr_i) == NIB_W'(7))))
            |-> (addr_o == $past(pc_i) + PC_W'(2)));

    // R5: loop branch taken exactly when the new count is nonzero
    a_r5_loop_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ($past(opr_i) == NIB_W'(7))) |-> (taken_o == (reg_inc_o != '0)));

    // R6: indirect jump is always taken
    a_r6_ijmp: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ($past(opr_i) == NIB_W'(3)) && $past(opa_i[0])) |-> taken_o);

    // R7: a fetch never reports a taken branch
    a_r7_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> (!taken_o && valid_o));
endmodule

// File: tb/sim_branch_unit.sv
module sim_branch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [11:0] pc_i = '0;
    logic [3:0]  opr_i = '0, opa_i = '0, reg_i = '0;
    logic [7:0]  word2_i = '0, pair_i = '0, pair0_i = '0;
    logic        acc_zero_i = 1'b0, carry_i = 1'b0, test_n_i = 1'b1;
    logic        valid_o, taken_o, fetch_o;
    logic [11:0] addr_o;
    logic [3:0]  reg_inc_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [11:0] pcs [5] = '{12'h0FE, 12'h0FF, 12'hFFE, 12'hFFF, 12'h5A3};

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i),
        .opr_i(opr_i), .opa_i(opa_i), .word2_i(word2_i),
        .acc_zero_i(acc_zero_i), .carry_i(carry_i), .test_n_i(test_n_i),
        .reg_i(reg_i), .pair_i(pair_i), .pair0_i(pair0_i),
        .valid_o(valid_o), .taken_o(taken_o), .fetch_o(fetch_o),
        .addr_o(addr_o), .reg_inc_o(reg_inc_o)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive a request at a falling edge, sample result at the next falling edge
    task automatic request(input logic [11:0] pc, input logic [3:0] opr, input logic [3:0] opa);
        pc_i = pc; opr_i = opr; opa_i = opa; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    function automatic logic [11:0] page_join(input logic [11:0] seq, input logic [7:0] off);
        return {seq[11:8], off};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: got %0d expected below %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", 16'(valid_o), 16'h0);
        check("R1 reset taken", 16'(taken_o), 16'h0);
        check("R1 reset addr", 16'(addr_o), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R8: all codes x all status combinations x edge addresses
        for (int p = 0; p < 5; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int s = 0; s < 8; s++) begin
                    logic [3:0] cc;
                    logic raw, exp_t;
                    logic [11:0] seq;
                    int hits;
                    cc = 4'(c);
                    acc_zero_i = s[0]; carry_i = s[1]; test_n_i = s[2];
                    word2_i = 8'(c * 17 + s);
                    hits = 0;
                    if (cc[2] && s[0]) hits++;
                    if (cc[1] && s[1]) hits++;
                    if (cc[0] && !s[2]) hits++;
                    raw = (hits > 0);
                    exp_t = cc[3] ? !raw : raw;
                    seq = pcs[p] + 12'd2;
                    request(pcs[p], 4'b0001, cc);
                    check("R3 cond taken", 16'(taken_o), 16'(exp_t));
                    check("R4 R8 cond addr", 16'(addr_o),
                          16'(exp_t ? page_join(seq, word2_i) : seq));
                    check("R1 valid", 16'(valid_o), 16'h1);
                end
            end
        end

        // R5 R8: all loop register values
        for (int p = 0; p < 5; p++) begin
            for (int r = 0; r < 16; r++) begin
                logic [3:0] inc;
                logic [11:0] seq;
                reg_i = 4'(r);
                word2_i = 8'(255 - r);
                inc = 4'((r + 1) % 16);
                seq = pcs[p] + 12'd2;
                request(pcs[p], 4'b0111, 4'(r));
                check("R5 loop inc", 16'(reg_inc_o), 16'(inc));
                check("R5 loop taken", 16'(taken_o), 16'(inc != 0));
                check("R5 R8 loop addr", 16'(addr_o),
                      16'(inc != 0 ? page_join(seq, word2_i) : seq));
            end
        end

        // R6 R7 R8: indirect jump and indirect fetch
        for (int p = 0; p < 5; p++) begin
            for (int v = 0; v < 4; v++) begin
                logic [11:0] seq;
                pair_i = 8'(v * 85);
                pair0_i = 8'(255 - v * 37);
                seq = pcs[p] + 12'd1;
                request(pcs[p], 4'b0011, 4'(2 * v + 1));
                check("R6 ijmp taken", 16'(taken_o), 16'h1);
                check("R6 R8 ijmp addr", 16'(addr_o), 16'(page_join(seq, pair_i)));
                request(pcs[p], 4'b0011, 4'(2 * v));
                check("R7 fetch flag", 16'(fetch_o), 16'h1);
                check("R7 fetch taken", 16'(taken_o), 16'h0);
                check("R7 R8 fetch addr", 16'(addr_o), 16'(page_join(seq, pair0_i)));
            end
        end

        // R2: every other operation nibble falls through to pc+1
        for (int o = 0; o < 16; o++) begin
            if (o == 1 || o == 3 || o == 7) continue;
            word2_i = 8'hA5; acc_zero_i = 1'b1; carry_i = 1'b1; test_n_i = 1'b0;
            request(12'hFFF, 4'(o), 4'hF);
            check("R2 other taken", 16'(taken_o), 16'h0);
            check("R2 other fetch", 16'(fetch_o), 16'h0);
            check("R2 other addr", 16'(addr_o), 16'h000);
        end

        // R1: idle cycle clears valid
        @(negedge clk);
        check("R1 idle valid", 16'(valid_o), 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule